// File: doc/BRIEF.md
# Dataflow Processing Element Arithmetic and Logic Unit

This block is the execute unit of a token-driven processing element. It is purely combinational. A 5-bit opcode, a left operand, a right operand and a per-activation frame constant produce a data result and a one-bit boolean in the same cycle. The block keeps no state and has no flags register. A comparison yields its truth value as ordinary data (0 or 1), and it also drives the boolean output.

The boolean output is what the downstream output formatter uses to steer routing. For compare, branch and switch opcodes it carries the comparator outcome. For GATE it carries bit 0 of the right operand. For every other opcode it is driven to 0. Shift amounts come from the low three bits of the frame constant, never from an operand. The datapath width is a parameter, intended for 8 or 16 bits.

Top module: `dfalu_core`

## Requirements
- R1: ADD (00000) returns lhs+rhs and SUB (00001) returns lhs-rhs, both modulo 2^DW; an all-zero ADD gives res_o=0 and bool_o=0.
- R2: INC (00010) returns lhs+1 and DEC (00011) returns lhs-1, modulo 2^DW; rhs_i and const_i have no effect.
- R3: AND (00100), OR (00101) and XOR (00110) are bitwise on lhs and rhs; NOT (00111) returns ~lhs and ignores rhs_i.
- R4: SHL (01000), SHR (01001) and ASR (01010) shift lhs by const_i[2:0] bits (0 to 7). SHL and SHR fill with zeros, and ASR fills with lhs's sign bit. Bits of const_i above bit 2 have no effect.
- R5: EQ (01011), LT (01100), LTE (01101), GT (01110) and GTE (01111) compare lhs against rhs as signed two's complement. res_o is 1 when true and 0 when false, and bool_o equals res_o[0]. This holds at the extremes (most negative versus most positive).
- R6: Branch codes 10000-10011 and switch codes 10100-10111 return lhs unchanged. bool_o is selected by the low two opcode bits: 00 gives lhs==rhs, 01 gives lhs>rhs, 10 gives lhs>=rhs (all signed), and 11 gives signed overflow of lhs+rhs (both addends share a sign that differs from the sum's sign).
- R7: GATE (11000) returns lhs, and bool_o = rhs[0].
- R8: SEL (11001) returns lhs when rhs[0]=1 and rhs otherwise; bool_o=0.
- R9: PASS (11011) returns lhs. CONST (11100) returns const_i and ignores lhs_i and rhs_i. Both drive bool_o=0.
- R10: MRGE (11010), FREE_FRAME (11101), ALLOC_REMOTE (11110) and reserved code 11111 return lhs with bool_o=0. The opcodes of R1-R4 also drive bool_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| lhs_i | input | DW | Left data operand |
| rhs_i | input | DW | Right data operand or boolean |
| const_i | input | DW | Frame constant; low 3 bits are the shift amount |
| res_o | output | DW | Data result |
| bool_o | output | 1 | Boolean result used for routing decisions |

## Verification
The checks assume that the opcode is always a known 5-bit value and that every code, including the reserved one, has a defined result. They also assume that DW is at least 8, so that every shift stage fits inside the word. The stimulus sweeps every opcode of an 8-bit instance across all left values, against right values that include zero, one and both sign extremes. Constants with high bits set exercise the shift-amount masking. A 16-bit instance receives every pairing of a small corner set that holds the two signed extremes.

// File: rtl/dfalu_pkg.sv
`timescale 1ns/1ps
package dfalu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'b00000, OP_SUB   = 5'b00001, OP_INC   = 5'b00010, OP_DEC   = 5'b00011,
    OP_AND   = 5'b00100, OP_OR    = 5'b00101, OP_XOR   = 5'b00110, OP_NOT   = 5'b00111,
    OP_SHL   = 5'b01000, OP_SHR   = 5'b01001, OP_ASR   = 5'b01010, OP_EQ    = 5'b01011,
    OP_LT    = 5'b01100, OP_LTE   = 5'b01101, OP_GT    = 5'b01110, OP_GTE   = 5'b01111,
    OP_BREQ  = 5'b10000, OP_BRGT  = 5'b10001, OP_BRGE  = 5'b10010, OP_BROF  = 5'b10011,
    OP_SWEQ  = 5'b10100, OP_SWGT  = 5'b10101, OP_SWGE  = 5'b10110, OP_SWOF  = 5'b10111,
    OP_GATE  = 5'b11000, OP_SEL   = 5'b11001, OP_MRGE  = 5'b11010, OP_PASS  = 5'b11011,
    OP_CONST = 5'b11100, OP_FREE  = 5'b11101, OP_ALLOC = 5'b11110, OP_RSVD  = 5'b11111
  } op_e;

  // low two bits of a branch/switch code select the condition
  typedef enum logic [1:0] {
    COND_EQ = 2'b00, COND_GT = 2'b01, COND_GE = 2'b10, COND_OF = 2'b11
  } cond_e;

  localparam int unsigned SHAMT_W = 3;
endpackage

// File: rtl/dfalu_addsub.sv
`timescale 1ns/1ps
module dfalu_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          zero_b_i,
  input  logic          inv_b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          ovf_o
);
  logic [DW-1:0] b_gated, b_eff;

  always_comb begin
    b_gated = zero_b_i ? '0 : b_i;
    b_eff   = inv_b_i ? ~b_gated : b_gated;
    sum_o   = a_i + b_eff + DW'(cin_i);
    // signed overflow of the addends actually applied
    ovf_o   = (a_i[DW-1] == b_eff[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
  end
endmodule

// File: rtl/dfalu_shifter.sv
`timescale 1ns/1ps
module dfalu_shifter #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input  logic [DW-1:0] a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] stg [SW+1];
  logic          fill;

  assign fill   = arith_i & a_i[DW-1];
  assign stg[0] = a_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    logic [DW-1:0] shl, shr;
    assign shl        = {stg[k][DW-1-D:0], {D{1'b0}}};
    assign shr        = {{D{fill}}, stg[k][DW-1:D]};
    assign stg[k+1]   = amt_i[k] ? (left_i ? shl : shr) : stg[k];
  end

  assign res_o = stg[SW];
endmodule

// File: rtl/dfalu_cmp.sv
`timescale 1ns/1ps
module dfalu_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          eq_o,
  output logic          lt_o,
  output logic          gt_o
);
  logic [DW-1:0] a_f, b_f;

  // flipping both sign bits maps signed order onto unsigned order
  assign a_f  = {~a_i[DW-1], a_i[DW-2:0]};
  assign b_f  = {~b_i[DW-1], b_i[DW-2:0]};
  assign eq_o = (a_f == b_f);
  assign lt_o = (a_f <  b_f);
  assign gt_o = (a_f >  b_f);
endmodule

// File: rtl/dfalu_core.sv
`timescale 1ns/1ps
module dfalu_core
  import dfalu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  input  logic [DW-1:0] const_i,
  output logic [DW-1:0] res_o,
  output logic          bool_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  op_e           op;
  logic          zero_b, inv_b, cin;
  logic [DW-1:0] sum;
  logic          ovf;
  logic [DW-1:0] shf;
  logic          eq, lt, gt;
  logic          cond;
  logic          is_brsw;

  assign op      = op_e'(op_i);
  assign is_brsw = (op_i[4:3] == 2'b10);

  always_comb begin
    zero_b = 1'b0;
    inv_b  = 1'b0;
    cin    = 1'b0;
    unique case (op)
      OP_SUB:  begin inv_b = 1'b1; cin = 1'b1; end
      OP_INC:  begin zero_b = 1'b1; cin = 1'b1; end
      OP_DEC:  begin zero_b = 1'b1; inv_b = 1'b1; end
      default: ;
    endcase
  end

  dfalu_addsub #(.DW(DW)) addsub_i (
    .a_i(lhs_i), .b_i(rhs_i), .zero_b_i(zero_b), .inv_b_i(inv_b),
    .cin_i(cin), .sum_o(sum), .ovf_o(ovf)
  );

  dfalu_shifter #(.DW(DW), .SW(SHAMT_W)) shifter_i (
    .a_i(lhs_i), .amt_i(const_i[SHAMT_W-1:0]),
    .left_i(op == OP_SHL), .arith_i(op == OP_ASR), .res_o(shf)
  );

  dfalu_cmp #(.DW(DW)) cmp_i (
    .a_i(lhs_i), .b_i(rhs_i), .eq_o(eq), .lt_o(lt), .gt_o(gt)
  );

  always_comb begin
    unique case (cond_e'(op_i[1:0]))
      COND_EQ: cond = eq;
      COND_GT: cond = gt;
      COND_GE: cond = gt | eq;
      default: cond = ovf;
    endcase
  end

  always_comb begin
    res_o  = lhs_i;
    bool_o = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: res_o = sum;
      OP_AND:  res_o = lhs_i & rhs_i;
      OP_OR:   res_o = lhs_i | rhs_i;
      OP_XOR:  res_o = lhs_i ^ rhs_i;
      OP_NOT:  res_o = ~lhs_i;
      OP_SHL, OP_SHR, OP_ASR: res_o = shf;
      OP_EQ:   begin bool_o = eq;      res_o = eq        ? ONE : '0; end
      OP_LT:   begin bool_o = lt;      res_o = lt        ? ONE : '0; end
      OP_LTE:  begin bool_o = lt | eq; res_o = (lt | eq) ? ONE : '0; end
      OP_GT:   begin bool_o = gt;      res_o = gt        ? ONE : '0; end
      OP_GTE:  begin bool_o = gt | eq; res_o = (gt | eq) ? ONE : '0; end
      OP_GATE: bool_o = rhs_i[0];
      OP_SEL:  res_o  = rhs_i[0] ? lhs_i : rhs_i;
      OP_CONST: res_o = const_i;
      default: if (is_brsw) bool_o = cond;
    endcase
  end
endmodule

// File: rtl/dfalu_chk.sv
`timescale 1ns/1ps
module dfalu_chk #(
  parameter int unsigned DW = 8
) (
  input logic [4:0]    op_i,
  input logic [DW-1:0] lhs_i,
  input logic [DW-1:0] rhs_i,
  input logic [DW-1:0] const_i,
  input logic [DW-1:0] res_o,
  input logic          bool_o
);
  always_comb begin
    if (op_i >= 5'b01011 && op_i <= 5'b01111) begin
      p_cmp_is_bool_r5: assert (res_o[DW-1:1] == '0 && res_o[0] == bool_o)
        else $error("compare result not 0/1 matching bool");
    end
    if (op_i[4:3] == 2'b10) begin
      p_brsw_pass_r6: assert (res_o == lhs_i) else $error("branch/switch altered data");
    end
    if (op_i == 5'b11000) begin
      p_gate_bool_r7: assert (bool_o == rhs_i[0] && res_o == lhs_i)
        else $error("gate bool or data wrong");
    end
    if (op_i == 5'b11001) begin
      p_sel_pick_r8: assert (res_o == (rhs_i[0] ? lhs_i : rhs_i) && !bool_o)
        else $error("select picked wrong operand");
    end
    if (op_i == 5'b11100) begin
      p_const_out_r9: assert (res_o == const_i) else $error("const not forwarded");
    end
    if (op_i < 5'b01011 || op_i > 5'b11000) begin
      p_bool_quiet_r10: assert (!bool_o) else $error("bool driven for non-boolean op");
    end
    if ((op_i == 5'b01001 || op_i == 5'b01010 || op_i == 5'b01000) && const_i[2:0] == 3'd0) begin
      p_shift_zero_r4: assert (res_o == lhs_i) else $error("zero shift altered data");
    end
  end
endmodule

bind dfalu_core dfalu_chk #(.DW(DW)) chk_i (
  .op_i(op_i), .lhs_i(lhs_i), .rhs_i(rhs_i), .const_i(const_i),
  .res_o(res_o), .bool_o(bool_o)
);

// File: tb/dfalu_core_tb_top.sv
`timescale 1ns/1ps
module dfalu_core_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks   = 0;
  int failures = 0;

  logic [4:0]  op8,  op16;
  logic [7:0]  l8, r8, c8, res8;
  logic [15:0] l16, r16, c16, res16;
  logic        b8, b16;

  dfalu_core #(.DW(8)) dut_i (
    .op_i(op8), .lhs_i(l8), .rhs_i(r8), .const_i(c8), .res_o(res8), .bool_o(b8)
  );
  dfalu_core #(.DW(16)) dut16_i (
    .op_i(op16), .lhs_i(l16), .rhs_i(r16), .const_i(c16), .res_o(res16), .bool_o(b16)
  );

  function automatic string tag_f(input int op);
    if (op <= 1)  return "R1";
    if (op <= 3)  return "R2";
    if (op <= 7)  return "R3";
    if (op <= 10) return "R4";
    if (op <= 15) return "R5";
    if (op <= 23) return "R6";
    if (op == 24) return "R7";
    if (op == 25) return "R8";
    if (op == 27 || op == 28) return "R9";
    return "R10";
  endfunction

  // returns {bool, result}
  function automatic logic [16:0] ref_f(input int w, input int op, input int l, input int r, input int c);
    int mask, sl, sr, s, res, amt;
    bit b;
    mask = (1 << w) - 1;
    l &= mask; r &= mask; c &= mask;
    sl = (l >= (1 << (w-1))) ? l - (1 << w) : l;
    sr = (r >= (1 << (w-1))) ? r - (1 << w) : r;
    amt = c & 7;
    b = 1'b0;
    res = l;
    case (op)
      0:  res = l + r;
      1:  res = l - r;
      2:  res = l + 1;
      3:  res = l - 1;
      4:  res = l & r;
      5:  res = l | r;
      6:  res = l ^ r;
      7:  res = ~l;
      8:  res = l << amt;
      9:  res = l >> amt;
      10: res = sl >>> amt;
      11: begin b = (sl == sr); res = int'(b); end
      12: begin b = (sl <  sr); res = int'(b); end
      13: begin b = (sl <= sr); res = int'(b); end
      14: begin b = (sl >  sr); res = int'(b); end
      15: begin b = (sl >= sr); res = int'(b); end
      24: b = r[0];
      25: res = r[0] ? l : r;
      28: res = c;
      default: ;
    endcase
    if (op >= 16 && op <= 23) begin
      s = sl + sr;
      case (op & 3)
        0: b = (sl == sr);
        1: b = (sl >  sr);
        2: b = (sl >= sr);
        default: b = (s > (1 << (w-1)) - 1) || (s < -(1 << (w-1)));
      endcase
    end
    res &= mask;
    return {b, res[15:0]};
  endfunction

  task automatic chk8(input int op, input int l, input int r, input int c);
    logic [16:0] e;
    op8 = op[4:0]; l8 = l[7:0]; r8 = r[7:0]; c8 = c[7:0];
    #1;
    e = ref_f(8, op, l, r, c);
    checks++;
    if (res8 !== e[7:0] || b8 !== e[16]) begin
      failures++;
      $display("FAIL %s w8 op=%0d l=%h r=%h c=%h res=%h exp=%h bool=%b exp=%b",
               tag_f(op), op, l8, r8, c8, res8, e[7:0], b8, e[16]);
    end
  endtask

  task automatic chk16(input int op, input int l, input int r, input int c);
    logic [16:0] e;
    op16 = op[4:0]; l16 = l[15:0]; r16 = r[15:0]; c16 = c[15:0];
    #1;
    e = ref_f(16, op, l, r, c);
    checks++;
    if (res16 !== e[15:0] || b16 !== e[16]) begin
      failures++;
      $display("FAIL %s w16 op=%0d l=%h r=%h c=%h res=%h exp=%h bool=%b exp=%b",
               tag_f(op), op, l16, r16, c16, res16, e[15:0], b16, e[16]);
    end
  endtask

  int corner16 [7] = '{0, 1, 'h7fff, 'h8000, 'hffff, 'h1234, 'hfedc};
  int cset16   [3] = '{0, 7, 'hfff9};

  initial begin
    op8 = '0; l8 = '0; r8 = '0; c8 = '0;
    op16 = '0; l16 = '0; r16 = '0; c16 = '0;
    // R1: idle all-zero ADD gives zero result and bool
    #5;
    checks++;
    if (res8 !== 8'h00 || b8 !== 1'b0) begin
      failures++;
      $display("FAIL R1 zero-input res=%h exp=00 bool=%b exp=0", res8, b8);
    end
    // R1..R10: 8-bit sweep, all left values against a spread of right values
    for (int op = 0; op < 32; op++)
      for (int l = 0; l < 256; l++)
        for (int ri = 0; ri < 19; ri++) begin
          int r;
          r = (ri < 16) ? ri * 17 : (ri == 16) ? 'h80 : (ri == 17) ? 'h7f : 1;
          chk8(op, l, r, (l ^ (ri * 37)) & 'hff);
        end
    // R5/R6: 16-bit extremes, most negative versus most positive included
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 3; k++)
            chk16(op, corner16[i], corner16[j], cset16[k]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule